// File: doc/BRIEF.md
# Byte-Lane SRAM With Single-Error Correction

This block is a synthesizable model of a word-wide static RAM that sits behind an asynchronous-style control port. The port has active-low controls: chip select, output enable, write enable, and one enable for each byte lane. Each 16-bit word is stored together with five Hamming check bits, so every stored entry is 21 bits wide. A read always returns the data after correction. A flag reports whether a single-bit fault was found and fixed during that read.

Writes are captured on the rising clock edge. Reads are combinational from the addressed entry, which matches the access behaviour of an asynchronous part. When a write enables only one byte lane, the block first corrects the old word, then merges in the new byte, then computes fresh check bits. A stored fault in the untouched lane is therefore repaired as a side effect of the write.

A test-only port can flip any one of the 21 stored bits at a chosen address, so that correction and the flag can be exercised. Tri-state behaviour is modelled with separate drive-enable outputs for each byte lane and for the flag. The array depth is a parameter. The word index is taken from the low address bits, and the upper address bits alias.

Top module: `sram_ecc_top`

## Requirements
- R1: A write of both lanes (cs_n=0, wr_en_n=0, lo_lane_n=0, hi_lane_n=0) at the rising edge stores din. A read of that address from the next cycle on returns the same word on dout.
- R2: In a write, din[7:0] is stored only when lo_lane_n=0, and din[15:8] only when hi_lane_n=0. A lane that is not enabled keeps its stored byte.
- R3: A read is active when cs_n=0, out_en_n=0, wr_en_n=1 and at least one lane enable is low. In a read, dout_lane_en[0] is set exactly when lo_lane_n=0, and dout_lane_en[1] exactly when hi_lane_n=0. The bits of a lane that is not driven read as 0 on dout.
- R4: dout_lane_en is 00 and flag_en is 0 whenever cs_n=1, or out_en_n=1, or both lane enables are high, or wr_en_n=0.
- R5: No entry changes when cs_n=1, or when both lane enables are high, even with wr_en_n=0.
- R6: A single flipped stored bit, at any of the 21 positions 0 to 20, is corrected, and the read returns the word that was written.
- R7: flag_en equals the read-active condition of R3. In a read, flag_err is 1 when a correction was made and 0 for a clean word. flag_err is 0 whenever flag_en is 0.
- R8: A write of one lane over a faulty word merges the new byte into the corrected old data and stores fresh check bits. Later reads of that word return flag_err=0.
- R9: When tinj_en=1 and tinj_pos is below 21, the stored bit at position tinj_pos of word tinj_addr is inverted at the rising edge. If tinj_pos is 21 or higher, nothing changes. If a write targets the same word in the same cycle, the write is stored and the flip is dropped.
- R10: After reset, every word reads as 0000 with flag_err=0.
- R11: Only the low log2(DEPTH) address bits select a word, so addresses that differ only in the upper bits refer to the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and bit flips take effect on its rising edge |
| rst_n | input | 1 | Active-low reset; clears every entry |
| cs_n | input | 1 | Active-low chip select |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| lo_lane_n | input | 1 | Active-low enable for bits 7:0 |
| hi_lane_n | input | 1 | Active-low enable for bits 15:8 |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data |
| dout | output | 16 | Corrected read data; bits of a lane that is not driven are 0 |
| dout_lane_en | output | 2 | Drive enable for each lane (bit 0 low byte, bit 1 high byte) |
| flag_err | output | 1 | Correction indicator |
| flag_en | output | 1 | Drive enable for flag_err |
| tinj_en | input | 1 | Test: flip one stored bit at the next edge |
| tinj_addr | input | ADDR_W | Test: word to flip |
| tinj_pos | input | 5 | Test: stored bit position, 0 to 20 |

## Verification
The read outputs (dout, dout_lane_en, flag_err and flag_en) follow the control and address inputs in the same cycle, with no register in between. Writes and bit flips take effect on the next rising edge, so their result first shows on a read in the cycle after the edge. The bench changes inputs on the falling edge and samples 1 ns later, well before the next rising edge. Every write or flip is therefore checked only through a read that starts at a later falling edge.

// File: rtl/sram_ecc_pkg.sv
`timescale 1ns/1ps
package sram_ecc_pkg;
  localparam int DATA_W = 16;
  localparam int CHK_W  = 5;
  localparam int CW_W   = DATA_W + CHK_W;
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [CHK_W-1:0]  syn_t;

  // position p (1-based) holds a check bit when p is a power of two
  function automatic logic is_chk_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic cw_t ham_encode(word_t d);
    cw_t cw;
    int  k;
    logic par;
    cw = '0;
    k  = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_chk_pos(p)) begin
        cw[p-1] = d[k];
        k++;
      end
    end
    for (int c = 0; c < CHK_W; c++) begin
      par = 1'b0;
      for (int p = 1; p <= CW_W; p++) begin
        if (((p >> c) & 1) == 1 && !is_chk_pos(p)) par ^= cw[p-1];
      end
      cw[(1 << c) - 1] = par;
    end
    return cw;
  endfunction

  function automatic syn_t ham_syndrome(cw_t cw);
    syn_t s;
    s = '0;
    for (int p = 1; p <= CW_W; p++) begin
      if (cw[p-1]) s ^= syn_t'(p);
    end
    return s;
  endfunction

  function automatic word_t ham_decode(cw_t cw);
    cw_t   fixed;
    syn_t  s;
    word_t d;
    int    k;
    s     = ham_syndrome(cw);
    fixed = cw;
    if (s != '0 && int'(s) <= CW_W) fixed[int'(s) - 1] = ~fixed[int'(s) - 1];
    d = '0;
    k = 0;
    for (int p = 1; p <= CW_W; p++) begin
      if (!is_chk_pos(p)) begin
        d[k] = fixed[p-1];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/sram_mode_decode.sv
`timescale 1ns/1ps
module sram_mode_decode (
  input  logic       cs_n,
  input  logic       out_en_n,
  input  logic       wr_en_n,
  input  logic       lo_lane_n,
  input  logic       hi_lane_n,
  output logic       wr_act,
  output logic [1:0] lane_wr,
  output logic       rd_act,
  output logic [1:0] lane_rd
);
  logic [1:0] lane_on;
  logic       any_lane;

  assign lane_on  = {~hi_lane_n, ~lo_lane_n};
  assign any_lane = |lane_on;
  assign wr_act   = ~cs_n & ~wr_en_n & any_lane;
  assign rd_act   = ~cs_n & wr_en_n & ~out_en_n & any_lane;
  assign lane_wr  = wr_act ? lane_on : 2'b00;
  assign lane_rd  = rd_act ? lane_on : 2'b00;
endmodule

// File: rtl/sram_ecc_store.sv
`timescale 1ns/1ps
module sram_ecc_store
  import sram_ecc_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_act,
  input  logic [1:0]       lane_wr,
  input  logic [IDX_W-1:0] idx,
  input  word_t            wdata,
  input  logic             inj_en,
  input  logic [IDX_W-1:0] inj_idx,
  input  logic [4:0]       inj_pos,
  output cw_t              rd_cw,
  output logic             wr_commit,
  output logic             inj_commit
);
  cw_t   mem [0:DEPTH-1];
  word_t old_fix;
  word_t merged;
  cw_t   new_cw;

  assign rd_cw   = mem[idx];
  assign old_fix = ham_decode(rd_cw);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] = lane_wr[g] ? wdata[g*LANE_W +: LANE_W]
                                                   : old_fix[g*LANE_W +: LANE_W];
  end

  assign new_cw     = ham_encode(merged);
  assign wr_commit  = wr_act;
  assign inj_commit = inj_en && (int'(inj_pos) < CW_W) && !(wr_act && inj_idx == idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr_commit) mem[idx] <= new_cw;
      if (inj_commit) mem[inj_idx][inj_pos] <= ~mem[inj_idx][inj_pos];
    end
  end
endmodule

// File: rtl/sram_ecc_top.sv
`timescale 1ns/1ps
module sram_ecc_top
  import sram_ecc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic              lo_lane_n,
  input  logic              hi_lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic [1:0]        dout_lane_en,
  output logic              flag_err,
  output logic              flag_en,
  input  logic              tinj_en,
  input  logic [ADDR_W-1:0] tinj_addr,
  input  logic [4:0]        tinj_pos
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             wr_act, rd_act, wr_commit, inj_commit, err_raw;
  logic [1:0]       lane_wr, lane_rd;
  logic [IDX_W-1:0] idx, inj_idx;
  cw_t              rd_cw;
  word_t            rd_fix;
  syn_t             rd_syn;
  logic             unused_hi;

  assign idx       = addr[IDX_W-1:0];
  assign inj_idx   = tinj_addr[IDX_W-1:0];
  assign unused_hi = ^{addr[ADDR_W-1:IDX_W], tinj_addr[ADDR_W-1:IDX_W], inj_commit};

  sram_mode_decode u_dec (
    .cs_n(cs_n), .out_en_n(out_en_n), .wr_en_n(wr_en_n),
    .lo_lane_n(lo_lane_n), .hi_lane_n(hi_lane_n),
    .wr_act(wr_act), .lane_wr(lane_wr), .rd_act(rd_act), .lane_rd(lane_rd)
  );

  sram_ecc_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .lane_wr(lane_wr), .idx(idx),
    .wdata(din), .inj_en(tinj_en), .inj_idx(inj_idx), .inj_pos(tinj_pos),
    .rd_cw(rd_cw), .wr_commit(wr_commit), .inj_commit(inj_commit)
  );

  assign rd_fix  = ham_decode(rd_cw);
  assign rd_syn  = ham_syndrome(rd_cw);
  assign err_raw = rd_syn != '0;

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign dout[g*LANE_W +: LANE_W] = lane_rd[g] ? rd_fix[g*LANE_W +: LANE_W] : '0;
  end

  assign dout_lane_en = lane_rd;
  assign flag_en      = rd_act;
  assign flag_err     = rd_act & err_raw;
endmodule

// File: rtl/sram_ecc_checker.sv
`timescale 1ns/1ps
module sram_ecc_checker
  import sram_ecc_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             out_en_n,
  input logic             wr_en_n,
  input logic             lo_lane_n,
  input logic             hi_lane_n,
  input logic [1:0]       dout_lane_en,
  input logic             flag_en,
  input logic             flag_err,
  input logic             wr_commit,
  input logic             tinj_en,
  input logic [IDX_W-1:0] idx,
  input cw_t              rd_cw,
  input logic             err_raw
);
  p_bus_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || out_en_n || !wr_en_n || (lo_lane_n && hi_lane_n)) |-> (dout_lane_en == 2'b00 && !flag_en));

  p_lane_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|dout_lane_en) |-> ((dout_lane_en & {hi_lane_n, lo_lane_n}) == 2'b00));

  p_flag_follows_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_en |-> (|dout_lane_en));

  p_flag_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |-> !flag_err);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_commit && !tinj_en) |=> ($stable(idx) -> $stable(rd_cw)));

  p_clean_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> ($stable(idx) -> !err_raw));
endmodule

bind sram_ecc_top sram_ecc_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .out_en_n(out_en_n), .wr_en_n(wr_en_n),
  .lo_lane_n(lo_lane_n), .hi_lane_n(hi_lane_n), .dout_lane_en(dout_lane_en),
  .flag_en(flag_en), .flag_err(flag_err), .wr_commit(wr_commit), .tinj_en(tinj_en),
  .idx(idx), .rd_cw(rd_cw), .err_raw(err_raw)
);

// File: tb/sram_ecc_top_test.sv
`timescale 1ns/1ps
module sram_ecc_top_test;
  localparam int AW = 20;
  localparam int DP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, out_en_n = 1'b1, wr_en_n = 1'b1, lo_lane_n = 1'b0, hi_lane_n = 1'b0;
  logic [AW-1:0] addr = '0, tinj_addr = '0;
  logic [15:0] din = '0, dout;
  logic [1:0]  dout_lane_en;
  logic        flag_err, flag_en, tinj_en = 1'b0;
  logic [4:0]  tinj_pos = '0;

  int checks = 0, failures = 0;
  logic [15:0] shadow [0:DP-1];

  always #2.5 clk = ~clk;

  sram_ecc_top #(.ADDR_W(AW), .DEPTH(DP)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .out_en_n(out_en_n), .wr_en_n(wr_en_n),
    .lo_lane_n(lo_lane_n), .hi_lane_n(hi_lane_n), .addr(addr), .din(din), .dout(dout),
    .dout_lane_en(dout_lane_en), .flag_err(flag_err), .flag_en(flag_en),
    .tinj_en(tinj_en), .tinj_addr(tinj_addr), .tinj_pos(tinj_pos)
  );

  function automatic logic [15:0] pat(int a);
    return 16'((a * 40503 + 4660) & 16'hFFFF);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_n = 1'b1; out_en_n = 1'b1; wr_en_n = 1'b1; lo_lane_n = 1'b0; hi_lane_n = 1'b0; tinj_en = 1'b0;
  endtask

  // write with out_en_n low too: the write must keep the bus released (R4)
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic lo, input logic hi);
    @(negedge clk);
    cs_n = 1'b0; out_en_n = 1'b0; wr_en_n = 1'b0; lo_lane_n = lo; hi_lane_n = hi; addr = a; din = d;
    #1;
    chk(dout_lane_en == 2'b00 && !flag_en, "R4 write keeps bus off", {dout_lane_en, flag_en}, 0);
    if (!lo) shadow[a % DP][7:0]  = d[7:0];
    if (!hi) shadow[a % DP][15:8] = d[15:8];
    @(negedge clk);
    idle();
  endtask

  task automatic rd_check(input logic [AW-1:0] a, input logic lo, input logic hi,
                          input logic exp_err, input string req);
    logic [15:0] e;
    logic [1:0]  eo;
    @(negedge clk);
    cs_n = 1'b0; out_en_n = 1'b0; wr_en_n = 1'b1; lo_lane_n = lo; hi_lane_n = hi; addr = a;
    #1;
    eo = {~hi, ~lo};
    e  = {hi ? 8'h00 : shadow[a % DP][15:8], lo ? 8'h00 : shadow[a % DP][7:0]};
    chk(dout == e, req, dout, e);
    chk(dout_lane_en == eo, req, dout_lane_en, eo);
    chk(flag_en == 1'b1 && flag_err == exp_err, req, {flag_en, flag_err}, {1'b1, exp_err});
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [4:0] pos);
    @(negedge clk);
    idle(); tinj_en = 1'b1; tinj_addr = a; tinj_pos = pos;
    @(negedge clk);
    tinj_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < DP; i++) shadow[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: reset contents
    rd_check(0, 1'b0, 1'b0, 1'b0, "R10 reset word 0");
    rd_check(37, 1'b0, 1'b0, 1'b0, "R10 reset word 37");

    // R1: full sweep of every word
    for (int a = 0; a < DP; a++) wr(AW'(a), pat(a), 1'b0, 1'b0);
    for (int a = 0; a < DP; a++) rd_check(AW'(a), 1'b0, 1'b0, 1'b0, "R1 sweep");

    // R11: upper address bits alias
    rd_check(20'hABC45, 1'b0, 1'b0, 1'b0, "R11 alias read");
    wr(20'hF0007, 16'h1234, 1'b0, 1'b0);
    rd_check(7, 1'b0, 1'b0, 1'b0, "R11 alias write");

    // R3: single-lane reads
    rd_check(9, 1'b0, 1'b1, 1'b0, "R3 low lane read");
    rd_check(9, 1'b1, 1'b0, 1'b0, "R3 high lane read");

    // R4: bus released in non-read modes
    @(negedge clk);
    cs_n = 1'b1; out_en_n = 1'b0; wr_en_n = 1'b1; addr = 5; #1;
    chk(dout_lane_en == 2'b00 && !flag_en, "R4 deselected", {dout_lane_en, flag_en}, 0);
    @(negedge clk);
    cs_n = 1'b0; out_en_n = 1'b1; #1;
    chk(dout_lane_en == 2'b00 && !flag_en, "R4 outputs disabled", {dout_lane_en, flag_en}, 0);
    @(negedge clk);
    out_en_n = 1'b0; lo_lane_n = 1'b1; hi_lane_n = 1'b1; #1;
    chk(dout_lane_en == 2'b00 && !flag_en, "R4 both lanes off", {dout_lane_en, flag_en}, 0);
    idle();

    // R5: write attempts that must not store
    @(negedge clk);
    cs_n = 1'b1; wr_en_n = 1'b0; addr = 12; din = 16'hDEAD;
    @(negedge clk);
    cs_n = 1'b0; lo_lane_n = 1'b1; hi_lane_n = 1'b1;
    @(negedge clk);
    idle();
    rd_check(12, 1'b0, 1'b0, 1'b0, "R5 word unchanged");

    // R2: single-lane writes
    wr(10, 16'hBEEF, 1'b0, 1'b1);
    rd_check(10, 1'b0, 1'b0, 1'b0, "R2 low lane write");
    wr(11, 16'hC0DE, 1'b1, 1'b0);
    rd_check(11, 1'b0, 1'b0, 1'b0, "R2 high lane write");

    // R6 / R7: every stored position, then restore
    for (int p = 0; p < 21; p++) begin
      inject(20, 5'(p));
      rd_check(20, 1'b0, 1'b0, 1'b1, "R6 corrected, R7 flag set");
      inject(20, 5'(p));
      rd_check(20, 1'b0, 1'b0, 1'b0, "R7 clean flag");
    end
    inject(21, 5'd12);
    rd_check(21, 1'b0, 1'b1, 1'b1, "R7 flag on low-lane read");
    inject(21, 5'd12);

    // R8: single-lane write over faulty word repairs it
    inject(30, 5'd18);
    wr(30, 16'h00A5, 1'b0, 1'b1);
    rd_check(30, 1'b0, 1'b0, 1'b0, "R8 merge high fault");
    inject(31, 5'd2);
    wr(31, 16'h5A00, 1'b1, 1'b0);
    rd_check(31, 1'b0, 1'b0, 1'b0, "R8 merge low fault");

    // R9: write beats flip on the same word; other word still flips
    @(negedge clk);
    cs_n = 1'b0; out_en_n = 1'b1; wr_en_n = 1'b0; lo_lane_n = 1'b0; hi_lane_n = 1'b0;
    addr = 40; din = 16'h7E57; tinj_en = 1'b1; tinj_addr = 40; tinj_pos = 5'd5;
    shadow[40] = 16'h7E57;
    @(negedge clk);
    idle();
    rd_check(40, 1'b0, 1'b0, 1'b0, "R9 write wins");
    @(negedge clk);
    cs_n = 1'b0; out_en_n = 1'b1; wr_en_n = 1'b0; lo_lane_n = 1'b0; hi_lane_n = 1'b0;
    addr = 41; din = 16'h4141; tinj_en = 1'b1; tinj_addr = 42; tinj_pos = 5'd7;
    shadow[41] = 16'h4141;
    @(negedge clk);
    idle();
    rd_check(41, 1'b0, 1'b0, 1'b0, "R9 write other word");
    rd_check(42, 1'b0, 1'b0, 1'b1, "R9 flip other word");
    inject(50, 5'd25);
    rd_check(50, 1'b0, 1'b0, 1'b0, "R9 position out of range");

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule